// File: doc/BRIEF.md
# Dual-Channel Line Mode Command Filter

This block sits behind the deserializer of a time-division control bus. Once per frame it receives one downstream control byte, which comes with a single-cycle frame strobe. The byte carries a 3-bit operating-mode command for each of two subscriber line channels and two handshake bits.

Each channel filters its command on its own. A new mode is adopted only when the same differing code arrives in two frames in a row. Isolated glitches and codes that keep changing never reach the line controller. Each channel keeps three pieces of state:

- an accepted register;
- a candidate register;
- a pending flag.

When a channel adopts a new mode it emits a one-cycle change pulse. A one-hot decode of the accepted mode is also available for each channel. The two handshake bits bypass the filter and are registered on every strobe.

Top module: `ctl_mode_filter_top`

## Requirements
- R1: After reset both accepted modes are 000 (open), no change pulse is raised, both pending flags are clear, the handshake outputs are 00 and each one-hot vector has only bit 0 set.
- R2: State and outputs change only in the clock cycle that follows a frame strobe. While `frame_vld` is low, the outputs hold their values whatever `frame_byte` carries; the exception is that a change pulse falls after one cycle.
- R3: A received code equal to the channel's accepted mode changes nothing.
- R4: A code that differs from the accepted mode starts a pending candidate. If the very next frame carries the same code, that code becomes the accepted mode. It appears on `mode_o` in the cycle after that second strobe.
- R5: While a candidate is pending, a code that differs from both the candidate and the accepted mode replaces the candidate and stays pending. Acceptance then needs one further identical frame.
- R6: While a candidate is pending, a code equal to the accepted mode cancels the candidate and leaves the accepted mode unchanged. A later frame carrying the old candidate code only starts a new pending candidate.
- R7: The byte layout is fixed:
  - bits 7:5 carry channel A, which is reported at index 0 of the outputs (`mode_o[2:0]`);
  - bits 4:2 carry channel B, which is reported at index 1 (`mode_o[5:3]`).
  The two channels filter independently.
- R8: `onehot_o[c*8 + k]` is 1 exactly when channel c's accepted code equals k. The codes are:

  | Code | Mode |
  |------|------|
  | 000 | open |
  | 001 | forward active |
  | 010 | forward on-hook transmission |
  | 011 | ground start, tip open |
  | 100 | ringing |
  | 101 | reverse active |
  | 110 | reverse on-hook transmission |
  | 111 | ground start, ring open |
- R9: On every strobe, byte bits 1:0 are registered without filtering and appear on `hs_o[1:0]` in the next cycle.
- R10: `chg_o[c]` is high for exactly one cycle each time channel c adopts a new mode, and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_vld | input | 1 | One-cycle frame strobe |
| frame_byte | input | 8 | Downstream control byte for this frame |
| mode_o | output | 6 | Accepted mode per channel, channel A in [2:0] |
| chg_o | output | 2 | One-cycle mode change pulse per channel |
| onehot_o | output | 16 | One-hot accepted mode, 8 bits per channel |
| hs_o | output | 2 | Registered handshake bits |

## Verification
The filter is driven with several code sequences, and each one separates a different way the filter could go wrong:

- Clean pairs of identical frames confirm that acceptance happens on the second frame and not on the first.
- Alternating triples, for example new, other, other, show that a third value restarts the count instead of being accepted.
- Sequences of the form new, old, new, new show that returning to the accepted mode discards the candidate.

Both channels receive different patterns in the same byte, which exposes swapped fields or state shared between channels. The handshake bits vary on every frame. Strobes are sent back to back and with long gaps, and `frame_byte` carries noise between strobes. A behavioural model checks every output on every cycle.

// File: rtl/ctl_mode_pkg.sv
`timescale 1ns/1ps
package ctl_mode_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_OPEN       = 3'd0,
        MODE_FWD_ACT    = 3'd1,
        MODE_FWD_OHT    = 3'd2,
        MODE_GS_TIP     = 3'd3,
        MODE_RINGING    = 3'd4,
        MODE_REV_ACT    = 3'd5,
        MODE_REV_OHT    = 3'd6,
        MODE_GS_RING    = 3'd7
    } line_mode_e;

endpackage

// File: rtl/ctl_code_filter.sv
`timescale 1ns/1ps
module ctl_code_filter #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] prim_o,
    output logic              chg_o
);

    typedef struct packed {
        logic [CODE_W-1:0] prim;
        logic [CODE_W-1:0] cand;
        logic              pend;
        logic              chg;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d     = flt_q;
        flt_d.chg = 1'b0;
        if (strobe) begin
            if (!flt_q.pend) begin
                if (code_i != flt_q.prim) begin
                    flt_d.cand = code_i;
                    flt_d.pend = 1'b1;
                end
            end else if (code_i == flt_q.cand) begin
                flt_d.prim = flt_q.cand;
                flt_d.pend = 1'b0;
                flt_d.chg  = 1'b1;
            end else if (code_i == flt_q.prim) begin
                flt_d.pend = 1'b0;
            end else begin
                flt_d.cand = code_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign prim_o = flt_q.prim;
    assign chg_o  = flt_q.chg;

endmodule

// File: rtl/ctl_mode_onehot.sv
`timescale 1ns/1ps
module ctl_mode_onehot #(
    parameter int CODE_W = 3,
    localparam int MODES = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [MODES-1:0]  onehot_o
);

    for (genvar k = 0; k < MODES; k++) begin : g_bit
        assign onehot_o[k] = (code_i == CODE_W'(k));
    end

endmodule

// File: rtl/ctl_mode_filter_top.sv
`timescale 1ns/1ps
module ctl_mode_filter_top
    import ctl_mode_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CODE_W = MODE_W,
    parameter int HS_W   = 2,
    localparam int BYTE_W = NUM_CH * CODE_W + HS_W,
    localparam int MODES  = 1 << CODE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_vld,
    input  logic [BYTE_W-1:0]          frame_byte,
    output logic [NUM_CH*CODE_W-1:0]   mode_o,
    output logic [NUM_CH-1:0]          chg_o,
    output logic [NUM_CH*MODES-1:0]    onehot_o,
    output logic [HS_W-1:0]            hs_o
);

    typedef struct packed {
        logic [HS_W-1:0] hs;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (frame_vld) begin
            hs_d.hs = frame_byte[HS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign hs_o = hs_q.hs;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int MSB = BYTE_W - 1 - c * CODE_W;
        logic [CODE_W-1:0] acc_mode;

        ctl_code_filter #(.CODE_W(CODE_W)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (frame_vld),
            .code_i (frame_byte[MSB -: CODE_W]),
            .prim_o (acc_mode),
            .chg_o  (chg_o[c])
        );

        ctl_mode_onehot #(.CODE_W(CODE_W)) dec_i (
            .code_i   (acc_mode),
            .onehot_o (onehot_o[c*MODES +: MODES])
        );

        assign mode_o[c*CODE_W +: CODE_W] = acc_mode;
    end

endmodule

// File: rtl/ctl_mode_filter_chk.sv
`timescale 1ns/1ps
module ctl_mode_filter_chk #(
    parameter int NUM_CH = 2,
    parameter int CODE_W = 3,
    parameter int HS_W   = 2,
    localparam int BYTE_W = NUM_CH * CODE_W + HS_W,
    localparam int MODES  = 1 << CODE_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     frame_vld,
    input logic [BYTE_W-1:0]        frame_byte,
    input logic [NUM_CH*CODE_W-1:0] mode_o,
    input logic [NUM_CH-1:0]        chg_o,
    input logic [NUM_CH*MODES-1:0]  onehot_o,
    input logic [HS_W-1:0]          hs_o
);

    // R9: handshake bits follow the byte of the previous strobe
    a_r9_hs_pass: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> hs_o == $past(frame_byte[HS_W-1:0]));

    // R2: no strobe, handshake output holds
    a_r2_hs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(hs_o));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam int MSB = BYTE_W - 1 - c * CODE_W;

        // R2: accepted mode holds when no strobe arrived
        a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_vld |=> $stable(mode_o[c*CODE_W +: CODE_W]));

        // R4: a mode change takes the code of the strobe just seen
        a_r4_new_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
            chg_o[c] |-> mode_o[c*CODE_W +: CODE_W] == $past(frame_byte[MSB -: CODE_W]));

        // R10: pulse marks a real change and lasts one cycle
        a_r10_pulse_change: assert property (@(posedge clk) disable iff (!rst_n)
            chg_o[c] |-> mode_o[c*CODE_W +: CODE_W] != $past(mode_o[c*CODE_W +: CODE_W]));
        a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
            chg_o[c] |=> !chg_o[c]);

        // R8: exactly one decoded bit per channel
        a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(onehot_o[c*MODES +: MODES]) == 1);
    end

endmodule

bind ctl_mode_filter_top ctl_mode_filter_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .HS_W   (HS_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_vld  (frame_vld),
    .frame_byte (frame_byte),
    .mode_o     (mode_o),
    .chg_o      (chg_o),
    .onehot_o   (onehot_o),
    .hs_o       (hs_o)
);

// File: tb/ctl_mode_filter_tb.sv
`timescale 1ns/1ps
module ctl_mode_filter_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_vld = 1'b0;
    logic [7:0]  frame_byte = 8'h00;
    logic [5:0]  mode_o;
    logic [1:0]  chg_o;
    logic [15:0] onehot_o;
    logic [1:0]  hs_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state
    int m_prim [2];
    int m_cand [2];
    int m_pend [2];
    int m_chg  [2];
    int m_hs;
    int noise = 0;

    always #5 clk = ~clk;

    ctl_mode_filter_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .frame_byte (frame_byte),
        .mode_o     (mode_o),
        .chg_o      (chg_o),
        .onehot_o   (onehot_o),
        .hs_o       (hs_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        for (int c = 0; c < 2; c++) begin
            chk(tag, $sformatf("ch%0d mode", c), int'(mode_o[c*3 +: 3]), m_prim[c]);
            chk({tag, "/R10"}, $sformatf("ch%0d chg", c), int'(chg_o[c]), m_chg[c]);
            chk({tag, "/R8"}, $sformatf("ch%0d onehot", c), int'(onehot_o[c*8 +: 8]), 1 << m_prim[c]);
        end
        chk({tag, "/R9"}, "hs", int'(hs_o), m_hs);
    endtask

    task automatic model_step(input logic [7:0] b);
        for (int c = 0; c < 2; c++) begin
            int code;
            code = (c == 0) ? int'(b[7:5]) : int'(b[4:2]);
            m_chg[c] = 0;
            if (m_pend[c] == 0) begin
                if (code != m_prim[c]) begin m_cand[c] = code; m_pend[c] = 1; end
            end else if (code == m_cand[c]) begin
                m_prim[c] = code; m_pend[c] = 0; m_chg[c] = 1;
            end else if (code == m_prim[c]) begin
                m_pend[c] = 0;
            end else begin
                m_cand[c] = code;
            end
        end
        m_hs = int'(b[1:0]);
    endtask

    // one frame, then gap idle cycles with noise on the byte (R2)
    task automatic frame(input int a, input int bch, input int hs, input int gap, input string tag);
        logic [7:0] b;
        b = {a[2:0], bch[2:0], hs[1:0]};
        frame_vld  = 1'b1;
        frame_byte = b;
        @(posedge clk);
        model_step(b);
        #2;
        compare(tag);
        frame_vld = 1'b0;
        for (int g = 0; g < gap; g++) begin
            noise      = noise * 37 + 11;
            frame_byte = noise[7:0];
            @(posedge clk);
            m_chg[0] = 0;
            m_chg[1] = 0;
            #2;
            compare("R2");
        end
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_prim[c] = 0; m_cand[c] = 0; m_pend[c] = 0; m_chg[c] = 0;
        end
        m_hs = 0;
        repeat (3) @(posedge clk);
        #2;
        compare("R1");
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        compare("R1");

        // R3: same as accepted
        frame(0, 0, 1, 2, "R3");
        // R4: clean pair on A, single then pair
        frame(1, 0, 2, 3, "R4");
        frame(1, 0, 3, 2, "R4");
        // R4 back to back strobes
        frame(4, 5, 0, 0, "R4");
        frame(4, 5, 1, 1, "R4");
        // R5: third value restarts
        frame(2, 5, 2, 1, "R5");
        frame(3, 5, 3, 1, "R5");
        frame(3, 5, 0, 1, "R5");
        frame(6, 5, 1, 0, "R5");
        frame(7, 5, 2, 0, "R5");
        frame(6, 5, 3, 0, "R5");
        frame(6, 5, 0, 2, "R5");
        // R6: return to accepted cancels
        frame(5, 5, 1, 1, "R6");
        frame(6, 5, 2, 1, "R6");
        frame(5, 5, 3, 1, "R6");
        frame(5, 5, 0, 1, "R6");
        // R7: channels independent with different patterns
        frame(1, 2, 1, 0, "R7");
        frame(1, 3, 2, 0, "R7");
        frame(2, 3, 3, 0, "R7");
        frame(2, 2, 0, 0, "R7");
        frame(2, 2, 1, 2, "R7");
        // R8: every code on each channel
        for (int k = 0; k < 8; k++) begin
            frame(k, 7 - k, k % 4, 0, "R8");
            frame(k, 7 - k, (k + 1) % 4, 1, "R8");
        end
        // R2: long idle with noise
        frame(3, 3, 2, 20, "R2");
        frame(3, 3, 1, 20, "R2");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule